// File: doc/BRIEF.md
# Cross-Thread Register Write Router

This block takes one 32-bit value from the issuing thread and stores it in a chosen register of a target thread context. The core holds several contexts. Each context owns these register groups:

- general registers
- a multiply accumulator and three further DSP accumulators, each with low, high and extension words, plus a DSP control word
- floating-point data and control registers
- coprocessor-2 data and control arrays
- a small system-register array

A unit bit, a select code and one or two index fields pick the destination. A half bit places the value in the upper or lower 32 bits of registers that are 64 bits wide.

Before any state is touched, two permission rules are applied. A write aimed at a context that lies beyond the implemented range is dropped. A write is also dropped when the issuer lacks multi-context privilege and the target belongs to a different virtual processor. Codes with no defined destination are reported as unpredictable and change nothing. Every strobe yields exactly one registered outcome pulse.

All register groups of all contexts share one flat address space. That space is held in two half-width memories, one for bits 31..0 and one for bits 63..32. A registered debug port reads back any register.

Top module: `xtc_write_router`

## Requirements
- R1: When `mvp_priv` is 0 and `tgt_vpe` differs from `own_vpe`, a strobe changes no register and pulses `ignored`. With `mvp_priv` 1, or with matching processor numbers, the write proceeds.
- R2: When `tgt_ctx` (4 bits) exceeds N_CTX-1 (3 by default), a strobe changes no register and pulses `ignored`. This drop takes priority over an unpredictable code.
- R3: For destinations that honour the half bit, `wr_half`=1 writes bits 63..32 and `wr_half`=0 writes bits 31..0. The other half keeps its value and is never filled with sign bits. At most one half is written per strobe.
- R4: With `wr_unit`=0, the destination is the system register at flat address 256 + {wr_sel[0], wr_rs}. The half bit applies, and wr_sel[2:1] do not affect the address.
- R5: With `wr_unit`=1 and `wr_sel`=0, general register `wr_rs` at flat address `wr_rs` is written. Only bits 31..0 are written, whatever `wr_half` is.
- R6: With `wr_unit`=1 and `wr_sel`=1, accumulator slot `wr_rs` at flat address 32 + `wr_rs` is written in bits 31..0. Slots 0..2, 4..6, 8..10 and 12..14 are the accumulator words, and slot 16 is the DSP control word. Any other `wr_rs` is unpredictable.
- R7: With `wr_unit`=1 and `wr_sel`=2, floating-point register `wr_rs` at flat address 64 + `wr_rs` is written. With `fp_wide`=1 (narrow general registers, wide FP registers), the half bit picks the half. With `fp_wide`=0 (equal widths), `wr_half`=0 writes bits 31..0 and `wr_half`=1 is unpredictable.
- R8: With `wr_unit`=1, three select codes write the following destinations:
  - `wr_sel`=3 writes FP control register `wr_rs` at flat address 96 + `wr_rs`, bits 31..0.
  - `wr_sel`=4 writes coprocessor-2 data at flat address 128 + {wr_rx, wr_rs}, and the half bit applies.
  - `wr_sel`=5 writes coprocessor-2 control at flat address 192 + {wr_rx, wr_rs}, and the half bit applies.
- R9: With `wr_unit`=1, `wr_sel` values 6 and 7 are unpredictable. Any unpredictable strobe leaves every register unchanged and pulses `unpred` for one cycle.
- R10: The following timing rules hold:
  - A strobe sampled at a rising edge updates its register at that edge.
  - At the same edge, exactly one of `applied`, `ignored` and `unpred` goes high, for one cycle.
  - No flag is high without a strobe or during reset.
- R11: `dbg_rdata` shows {bits 63..32, bits 31..0} of register `dbg_addr` in context `dbg_ctx`, registered one edge after the address is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| wr_en | input | 1 | Write strobe, one per write |
| wr_data | input | 32 | Value to place |
| wr_rs | input | 5 | Primary register index |
| wr_rx | input | 1 | Extra index bit for coprocessor-2 arrays |
| wr_unit | input | 1 | 0: system register, 1: per-thread register groups |
| wr_sel | input | 3 | Register group select |
| wr_half | input | 1 | 1: upper half, 0: lower half |
| tgt_ctx | input | 4 | Target context number |
| tgt_vpe | input | 2 | Virtual processor the target context is bound to |
| own_vpe | input | 2 | Virtual processor of the issuing context |
| mvp_priv | input | 1 | Issuer may reach contexts of other virtual processors |
| fp_wide | input | 1 | FP registers twice as wide as general registers |
| dbg_ctx | input | 2 | Context for the debug read |
| dbg_addr | input | 9 | Flat register address for the debug read |
| applied | output | 1 | A register was updated |
| ignored | output | 1 | Write dropped by a permission rule |
| unpred | output | 1 | Write had an undefined destination |
| dbg_rdata | output | 64 | Debug read data |

## Verification
The three outcome flags are due at the rising edge that samples the strobe. The monitor compares them 1 ns after that edge, while the strobe is still held, so every strobe is matched to exactly one queued outcome. A debug read is due one edge after its address is presented, and it is compared at the same offset.

Writes and reads always occupy separate cycles, so read-during-write ordering never matters. Each dropped or undefined write is followed by a read of a register preloaded earlier; this shows at the ports that nothing changed.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;
  localparam int CP2X_W = 1;
  localparam int SYS_SW = 1;
  localparam int REG_AW = 9;

  // flat register map per context
  localparam logic [REG_AW-1:0] GPR_BASE  = 9'd0;
  localparam logic [REG_AW-1:0] ACC_BASE  = 9'd32;
  localparam logic [REG_AW-1:0] FPR_BASE  = 9'd64;
  localparam logic [REG_AW-1:0] FPCR_BASE = 9'd96;
  localparam logic [REG_AW-1:0] CP2D_BASE = 9'd128;
  localparam logic [REG_AW-1:0] CP2C_BASE = 9'd192;
  localparam logic [REG_AW-1:0] SYS_BASE  = 9'd256;

  localparam logic [IDX_W-1:0] ACC_LAST_IDX = 5'd14;
  localparam logic [IDX_W-1:0] ACC_CTRL_IDX = 5'd16;

  localparam logic [2:0] SEL_GPR  = 3'd0;
  localparam logic [2:0] SEL_ACC  = 3'd1;
  localparam logic [2:0] SEL_FPR  = 3'd2;
  localparam logic [2:0] SEL_FPCR = 3'd3;
  localparam logic [2:0] SEL_CP2D = 3'd4;
  localparam logic [2:0] SEL_CP2C = 3'd5;

  typedef enum logic [1:0] {
    OC_NONE  = 2'd0,
    OC_APPLY = 2'd1,
    OC_DROP  = 2'd2,
    OC_BAD   = 2'd3
  } outcome_t;

  typedef struct packed {
    logic hi;
    logic lo;
  } half_en_t;
endpackage

// File: rtl/xtc_access_gate.sv
module xtc_access_gate #(
  parameter int N_CTX  = 4,
  parameter int CTX_FW = 4,
  parameter int VPE_W  = 2
) (
  input  logic [CTX_FW-1:0] tgt_ctx,
  input  logic [VPE_W-1:0]  tgt_vpe,
  input  logic [VPE_W-1:0]  own_vpe,
  input  logic              mvp_priv,
  output logic              drop
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [CTX_FW-1:0] LAST_CTX = CTX_FW'(N_CTX - 1);

  logic foreign_vpe;
  logic out_of_range;

  assign foreign_vpe  = !mvp_priv && (tgt_vpe != own_vpe);
  assign out_of_range = tgt_ctx > LAST_CTX;
  assign drop         = foreign_vpe || out_of_range;
endmodule

// File: rtl/xtc_dest_decode.sv
module xtc_dest_decode
  import xtc_pkg::*;
(
  input  logic                unit_u,
  input  logic [2:0]          sel,
  input  logic [IDX_W-1:0]    rs,
  input  logic [CP2X_W-1:0]   rx,
  input  logic                half_h,
  input  logic                fp_wide,
  output logic [REG_AW-1:0]   addr,
  output half_en_t            hen,
  output logic                bad
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [IDX_W+CP2X_W-1:0] cp2_idx;
  logic [IDX_W+SYS_SW-1:0] sys_idx;
  logic                    acc_ok;
  half_en_t                by_half;
  half_en_t                low_only;

  assign cp2_idx  = {rx, rs};
  assign sys_idx  = {sel[SYS_SW-1:0], rs};
  assign acc_ok   = (rs == ACC_CTRL_IDX) || ((rs <= ACC_LAST_IDX) && (rs[1:0] != 2'b11));
  assign by_half  = '{hi: half_h, lo: !half_h};
  assign low_only = '{hi: 1'b0, lo: 1'b1};

  always_comb begin
    addr = '0;
    hen  = '0;
    bad  = 1'b0;
    if (!unit_u) begin
      addr = SYS_BASE + REG_AW'(sys_idx);
      hen  = by_half;
    end else begin
      unique case (sel)
        SEL_GPR: begin
          addr = GPR_BASE + REG_AW'(rs);
          hen  = low_only;
        end
        SEL_ACC: begin
          addr = ACC_BASE + REG_AW'(rs);
          if (acc_ok) hen = low_only;
          else bad = 1'b1;
        end
        SEL_FPR: begin
          addr = FPR_BASE + REG_AW'(rs);
          if (fp_wide) hen = by_half;
          else if (!half_h) hen = low_only;
          else bad = 1'b1;
        end
        SEL_FPCR: begin
          addr = FPCR_BASE + REG_AW'(rs);
          hen  = low_only;
        end
        SEL_CP2D: begin
          addr = CP2D_BASE + REG_AW'(cp2_idx);
          hen  = by_half;
        end
        SEL_CP2C: begin
          addr = CP2C_BASE + REG_AW'(cp2_idx);
          hen  = by_half;
        end
        default: bad = 1'b1;
      endcase
    end
  end

  always_comb begin
    AST_ONE_HALF: assert ($onehot0({hen.hi, hen.lo})); // R3
  end
endmodule

// File: rtl/xtc_reg_bank.sv
module xtc_reg_bank #(
  parameter int AW = 11,
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic [1:0]      we,
  input  logic [AW-1:0]   waddr,
  input  logic [HW-1:0]   wdata,
  input  logic [AW-1:0]   raddr,
  output logic [2*HW-1:0] rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 2 ** AW;

  // one simple dual-port RAM per 32-bit half, read-first
  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [HW-1:0] mem [DEPTH];
    logic [HW-1:0] q;
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata;
      q <= mem[raddr];
    end
    assign rdata[g*HW +: HW] = q;
  end
endmodule

// File: rtl/xtc_write_router.sv
module xtc_write_router
  import xtc_pkg::*;
#(
  parameter int N_CTX  = 4,
  parameter int CTX_FW = 4,
  parameter int VPE_W  = 2,
  parameter int CTX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    wr_rs,
  input  logic [CP2X_W-1:0]   wr_rx,
  input  logic                wr_unit,
  input  logic [2:0]          wr_sel,
  input  logic                wr_half,
  input  logic [CTX_FW-1:0]   tgt_ctx,
  input  logic [VPE_W-1:0]    tgt_vpe,
  input  logic [VPE_W-1:0]    own_vpe,
  input  logic                mvp_priv,
  input  logic                fp_wide,
  input  logic [CTX_W-1:0]    dbg_ctx,
  input  logic [REG_AW-1:0]   dbg_addr,
  output logic                applied,
  output logic                ignored,
  output logic                unpred,
  output logic [2*DATA_W-1:0] dbg_rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BANK_AW = CTX_W + REG_AW;

  logic              drop;
  logic [REG_AW-1:0] dst_addr;
  half_en_t          dst_hen;
  logic              dst_bad;
  outcome_t          oc;
  logic [1:0]        bank_we;

  xtc_access_gate #(
    .N_CTX (N_CTX),
    .CTX_FW(CTX_FW),
    .VPE_W (VPE_W)
  ) u_gate (
    .tgt_ctx (tgt_ctx),
    .tgt_vpe (tgt_vpe),
    .own_vpe (own_vpe),
    .mvp_priv(mvp_priv),
    .drop    (drop)
  );

  xtc_dest_decode u_dec (
    .unit_u (wr_unit),
    .sel    (wr_sel),
    .rs     (wr_rs),
    .rx     (wr_rx),
    .half_h (wr_half),
    .fp_wide(fp_wide),
    .addr   (dst_addr),
    .hen    (dst_hen),
    .bad    (dst_bad)
  );

  // permission rules outrank the destination check
  always_comb begin
    if (!wr_en)       oc = OC_NONE;
    else if (drop)    oc = OC_DROP;
    else if (dst_bad) oc = OC_BAD;
    else              oc = OC_APPLY;
  end

  assign bank_we = (oc == OC_APPLY) ? {dst_hen.hi, dst_hen.lo} : 2'b00;

  xtc_reg_bank #(
    .AW(BANK_AW),
    .HW(DATA_W)
  ) u_bank (
    .clk  (clk),
    .we   (bank_we),
    .waddr({tgt_ctx[CTX_W-1:0], dst_addr}),
    .wdata(wr_data),
    .raddr({dbg_ctx, dbg_addr}),
    .rdata(dbg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      applied <= 1'b0;
      ignored <= 1'b0;
      unpred  <= 1'b0;
    end else begin
      applied <= (oc == OC_APPLY);
      ignored <= (oc == OC_DROP);
      unpred  <= (oc == OC_BAD);
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst) $onehot0({applied, ignored, unpred})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !wr_en |=> !(applied || ignored || unpred)); // R10
  AST_STROBE_FLAG: assert property (@(posedge clk) disable iff (rst) wr_en |=> (applied || ignored || unpred)); // R10
  AST_RANGE_DROP: assert property (@(posedge clk) disable iff (rst) (wr_en && (tgt_ctx > CTX_FW'(N_CTX - 1))) |=> ignored); // R2
  AST_PRIV_DROP: assert property (@(posedge clk) disable iff (rst) (wr_en && !mvp_priv && (own_vpe != tgt_vpe)) |=> ignored); // R1
  AST_HIGH_SEL: assert property (@(posedge clk) disable iff (rst) (wr_en && !drop && wr_unit && (wr_sel > 3'd5)) |=> unpred); // R9
endmodule

// File: tb/sim_xtc_write_router.sv
module sim_xtc_write_router;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4:0]  wr_rs = '0;
  logic [0:0]  wr_rx = '0;
  logic        wr_unit = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic        wr_half = 1'b0;
  logic [3:0]  tgt_ctx = '0;
  logic [1:0]  tgt_vpe = '0;
  logic [1:0]  own_vpe = '0;
  logic        mvp_priv = 1'b1;
  logic        fp_wide = 1'b0;
  logic [1:0]  dbg_ctx = '0;
  logic [8:0]  dbg_addr = '0;
  logic        applied, ignored, unpred;
  logic [63:0] dbg_rdata;
  logic        rd_pend = 1'b0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] fl;   // {unpred, ignored, applied}
    string      tag;
  } wexp_t;
  typedef struct {
    logic [63:0] val;
    logic [63:0] msk;
    string       tag;
  } rexp_t;

  wexp_t wq[$];
  rexp_t rq[$];
  logic [63:0] mval [int];
  logic [63:0] mmsk [int];

  always #2.5 clk = ~clk;  // 200 MHz

  xtc_write_router u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_rs(wr_rs),
    .wr_rx(wr_rx), .wr_unit(wr_unit), .wr_sel(wr_sel), .wr_half(wr_half),
    .tgt_ctx(tgt_ctx), .tgt_vpe(tgt_vpe), .own_vpe(own_vpe), .mvp_priv(mvp_priv),
    .fp_wide(fp_wide), .dbg_ctx(dbg_ctx), .dbg_addr(dbg_addr),
    .applied(applied), .ignored(ignored), .unpred(unpred), .dbg_rdata(dbg_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // destination per the requirement text
  function automatic void dest(input bit u, input bit [2:0] s, input bit [4:0] rs, input bit rx,
                               input bit h, input bit wide, output bit bad, output int a,
                               output bit lo, output bit hi);
    bad = 0; a = 0; lo = 0; hi = 0;
    if (!u) begin
      a = 256 + int'({s[0], rs}); lo = !h; hi = h;
    end else begin
      case (s)
        3'd0: begin a = int'(rs); lo = 1; end
        3'd1: begin
          a = 32 + int'(rs);
          if (rs == 16 || (rs <= 14 && rs[1:0] != 2'b11)) lo = 1; else bad = 1;
        end
        3'd2: begin
          a = 64 + int'(rs);
          if (wide) begin lo = !h; hi = h; end
          else if (!h) lo = 1;
          else bad = 1;
        end
        3'd3: begin a = 96 + int'(rs); lo = 1; end
        3'd4: begin a = 128 + int'({rx, rs}); lo = !h; hi = h; end
        3'd5: begin a = 192 + int'({rx, rs}); lo = !h; hi = h; end
        default: bad = 1;
      endcase
    end
  endfunction

  task automatic do_wr(input bit u, input bit [2:0] s, input bit [4:0] rs, input bit rx, input bit h,
                       input bit [3:0] ctx, input bit [31:0] d, input string tag);
    bit drop, bad, lo, hi;
    int a, key;
    wexp_t e;
    @(negedge clk);
    wr_unit = u; wr_sel = s; wr_rs = rs; wr_rx = rx; wr_half = h;
    tgt_ctx = ctx; wr_data = d; wr_en = 1'b1;
    drop = (!mvp_priv && (own_vpe != tgt_vpe)) || (ctx > 4'd3);
    dest(u, s, rs, rx, h, fp_wide, bad, a, lo, hi);
    e.tag = tag;
    if (drop)     e.fl = 3'b010;
    else if (bad) e.fl = 3'b100;
    else          e.fl = 3'b001;
    wq.push_back(e);
    if (!drop && !bad) begin
      key = int'(ctx) * 512 + a;
      if (!mval.exists(key)) begin mval[key] = '0; mmsk[key] = '0; end
      if (lo) begin mval[key][31:0]  = d; mmsk[key][31:0]  = '1; end
      if (hi) begin mval[key][63:32] = d; mmsk[key][63:32] = '1; end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input int ctx, input int addr, input string tag);
    rexp_t r;
    int key;
    @(negedge clk);
    dbg_ctx = 2'(ctx); dbg_addr = 9'(addr); rd_pend = 1'b1;
    key = ctx * 512 + addr;
    r.tag = tag;
    r.val = mval.exists(key) ? mval[key] : '0;
    r.msk = mmsk.exists(key) ? mmsk[key] : '0;
    rq.push_back(r);
    @(negedge clk);
    rd_pend = 1'b0;
  endtask

  // monitor: results due at the edge that samples the strobe / address
  always @(posedge clk) begin : mon
    wexp_t e;
    rexp_t r;
    #1;
    if (!rst) begin
      if (wr_en) begin
        if (wq.size() == 0) check(0, "R10 strobe without expectation", 64'(wr_en), 64'd0);
        else begin
          e = wq.pop_front();
          check({unpred, ignored, applied} == e.fl, e.tag, 64'({unpred, ignored, applied}), 64'(e.fl));
        end
      end else begin
        check({unpred, ignored, applied} == 3'b000, "R10 no flag when idle",
              64'({unpred, ignored, applied}), 64'd0);
      end
      if (rd_pend) begin
        if (rq.size() == 0) check(0, "R11 read without expectation", dbg_rdata, 64'd0);
        else begin
          r = rq.pop_front();
          check((dbg_rdata & r.msk) == (r.val & r.msk), r.tag, dbg_rdata & r.msk, r.val & r.msk);
        end
      end
    end
  end

  initial begin : watchdog
    #900us;
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    check({unpred, ignored, applied} == 3'b000, "R10 flags low in reset", 64'({unpred, ignored, applied}), 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // general registers
    do_wr(1, 3'd0, 5'd7, 0, 0, 4'd1, 32'hA5A5_0007, "R5 gpr write flag");
    do_rd(1, 7, "R5 gpr readback");
    do_wr(1, 3'd0, 5'd8, 0, 1, 4'd1, 32'h0BAD_0008, "R5 gpr with half bit set");
    do_rd(1, 8, "R5 gpr half bit has no effect");

    // system registers and half placement
    do_wr(0, 3'd1, 5'd3, 0, 1, 4'd2, 32'h1234_5678, "R4 sys high half");
    do_wr(0, 3'd1, 5'd3, 0, 0, 4'd2, 32'h8000_0000, "R3 sys low half");
    do_rd(2, 291, "R3 halves kept, no sign fill");
    do_wr(0, 3'd0, 5'd3, 0, 0, 4'd2, 32'h0000_0005, "R4 sys sel0");
    do_rd(2, 259, "R4 sys sel0 address");
    do_wr(0, 3'd7, 5'd3, 0, 1, 4'd2, 32'hCAFE_0001, "R4 sys upper sel bits");
    do_rd(2, 291, "R4 sel bits 2..1 ignored");

    // accumulators
    do_wr(1, 3'd1, 5'd0, 0, 0, 4'd0, 32'h0000_AC00, "R6 acc lo");
    do_wr(1, 3'd1, 5'd5, 0, 0, 4'd0, 32'h0000_AC05, "R6 dsp acc1 hi");
    do_wr(1, 3'd1, 5'd16, 0, 0, 4'd0, 32'h0000_AC16, "R6 dsp control");
    do_rd(0, 32, "R6 acc lo readback");
    do_rd(0, 37, "R6 acc1 readback");
    do_rd(0, 48, "R6 control readback");
    do_wr(1, 3'd1, 5'd3, 0, 0, 4'd0, 32'h1, "R6 slot 3 unpredictable");
    do_wr(1, 3'd1, 5'd15, 0, 0, 4'd0, 32'h1, "R6 slot 15 unpredictable");
    do_wr(1, 3'd1, 5'd17, 0, 0, 4'd0, 32'h1, "R6 slot 17 unpredictable");
    do_rd(0, 48, "R9 control unchanged after unpredictable");

    // floating-point registers
    fp_wide = 1'b1;
    do_wr(1, 3'd2, 5'd4, 0, 1, 4'd3, 32'hF00D_0004, "R7 wide fpr high");
    do_wr(1, 3'd2, 5'd4, 0, 0, 4'd3, 32'hFFFF_FFFF, "R7 wide fpr low");
    do_rd(3, 68, "R7 wide fpr halves");
    fp_wide = 1'b0;
    do_wr(1, 3'd2, 5'd4, 0, 1, 4'd3, 32'hDEAD_DEAD, "R7 narrow high unpredictable");
    do_rd(3, 68, "R9 fpr unchanged after unpredictable");
    do_wr(1, 3'd2, 5'd4, 0, 0, 4'd3, 32'h0000_4444, "R7 narrow low");
    do_rd(3, 68, "R7 narrow low readback");

    // FP control and coprocessor-2
    do_wr(1, 3'd3, 5'd31, 0, 1, 4'd0, 32'h0000_0C31, "R8 fp control");
    do_rd(0, 127, "R8 fp control readback");
    do_wr(1, 3'd4, 5'd2, 1, 1, 4'd1, 32'hC2D0_0022, "R8 cp2 data high");
    do_rd(1, 162, "R8 cp2 data with rx");
    do_wr(1, 3'd5, 5'd2, 0, 0, 4'd1, 32'hC2C0_0002, "R8 cp2 control low");
    do_rd(1, 194, "R8 cp2 control readback");

    // undefined selects
    do_wr(1, 3'd6, 5'd0, 0, 0, 4'd0, 32'h6, "R9 sel 6 unpredictable");
    do_wr(1, 3'd7, 5'd0, 0, 0, 4'd0, 32'h7, "R9 sel 7 unpredictable");
    do_rd(0, 127, "R9 state unchanged after sel 6/7");

    // privilege rule
    do_wr(1, 3'd0, 5'd9, 0, 0, 4'd1, 32'h0000_0909, "R1 preload");
    mvp_priv = 1'b0; own_vpe = 2'd1; tgt_vpe = 2'd2;
    do_wr(1, 3'd0, 5'd9, 0, 0, 4'd1, 32'hBAD0_0009, "R1 foreign vpe dropped");
    do_rd(1, 9, "R1 dropped write left register");
    tgt_vpe = 2'd1;
    do_wr(1, 3'd0, 5'd9, 0, 0, 4'd1, 32'h0000_1919, "R1 same vpe applied");
    mvp_priv = 1'b1; tgt_vpe = 2'd3;
    do_wr(1, 3'd0, 5'd9, 0, 0, 4'd1, 32'h0000_2929, "R1 privileged applied");
    do_rd(1, 9, "R1 privileged readback");

    // context range rule
    own_vpe = 2'd0; tgt_vpe = 2'd0;
    do_wr(1, 3'd0, 5'd10, 0, 0, 4'd1, 32'h0000_1010, "R2 preload");
    do_wr(1, 3'd0, 5'd10, 0, 0, 4'd5, 32'hBAD0_0010, "R2 context 5 dropped");
    do_rd(1, 10, "R2 aliased context untouched");
    do_wr(1, 3'd0, 5'd10, 0, 0, 4'd3, 32'h0000_3010, "R2 last context applied");
    do_rd(3, 10, "R2 last context readback");
    do_wr(1, 3'd7, 5'd0, 0, 0, 4'd15, 32'h0, "R2 drop outranks unpredictable");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule